// File: doc/BRIEF.md
# Self-Calibrating Serial Host Interface

This block is the host-facing serial port of a bridge between a host serial line and a single-wire device bus. It receives and sends asynchronous characters of eight data bits, no parity and one stop bit. There is no fixed baud divisor. After every master reset the block measures the low time of the start bit of the first character it receives, in system clock cycles. That measurement becomes the bit period for all later sampling and for transmission. The calibration character is absorbed and is not passed on.

Each received byte after calibration is handed to a downstream command processor as a one-cycle valid pulse. Response bytes from that processor enter through a ready/valid pair and are serialized onto the outgoing line. A configuration input inverts the outgoing line.

A low level sampled where the stop bit belongs is treated as a master reset, with the same effect as power-on. A break, a NULL character sent at half the rate, or a character carrying a space parity bit all produce this condition. The master reset clears every partial character, returns the mode flag to command mode, and requires a new calibration character. The mode flag can be moved to data mode and back by the downstream processor.

Top module: `autobaud_host_if`

## Requirements
- R1: A received character is a low start bit, eight data bits sent least significant bit first, and a high stop bit, each lasting one calibrated period P. After calibration, each such character is presented on `rx_data` together with a `rx_valid` pulse of exactly one cycle.
- R2: A character followed by two stop bits is received correctly, and the next character is received correctly as well.
- R3: An accepted transmit byte (`tx_valid` and `tx_ready` high at a clock edge) appears on the line as one low start bit, eight data bits least significant bit first, and exactly one high stop bit, each P cycles long. `tx_ready` is low for exactly 10·P cycles after the accepting edge.
- R4: While `rst` is high and right after it: `cmd_mode` is 1, `tx_ready` is 0, and the line is idle (`ser_out` equals the inverse of `cfg_inv`).
- R5: After any master reset, P is set to the number of cycles the first start bit stays low. The calibration character must have data bit 0 equal to 1, and it never produces `rx_valid`. `tx_ready` rises once that character's stop bit has been sampled.
- R6: While the block waits for calibration, a low pulse shorter than MIN_BIT cycles is ignored and does not set P.
- R7: After calibration, a falling edge starts a character only if the line is still low P/2 cycles later. A shorter low glitch yields no byte and no error.
- R8: A low level sampled at the mid-stop position causes a master reset. On the next cycle `mreset_pulse` is high for one cycle, `cmd_mode` is 1, `tx_ready` is 0, any character being sent is dropped with the line idle, no byte is delivered for the broken frame, and calibration is required again.
- R9: With `cfg_inv` = 1 the outgoing line is inverted: it idles low, start is high and data bits are complemented.
- R10: A `go_data` pulse clears `cmd_mode`. A `go_cmd` pulse sets it, and `go_cmd` wins when both pulses arrive together. A master reset sets it.
- R11: Until calibration completes, `rx_valid` stays low and `tx_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ser_in | input | 1 | Serial line from the host (idle high) |
| ser_out | output | 1 | Serial line to the host |
| cfg_inv | input | 1 | Invert the outgoing serial line when 1 |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit request |
| tx_ready | output | 1 | Transmitter calibrated and idle |
| go_data | input | 1 | Switch the mode flag to data mode |
| go_cmd | input | 1 | Switch the mode flag to command mode |
| cmd_mode | output | 1 | 1 while in command mode |
| mreset_pulse | output | 1 | One-cycle pulse after a stop-position master reset |

## Verification
The embedded properties take several things as given. The host holds `tx_valid` and `tx_data` steady only as a plain request, with no further protocol. Characters on `ser_in` arrive no closer together than one full period. The calibration start bit is at least MIN_BIT cycles long. The stimulus keeps to these limits: the host model drives whole characters at a fixed cycle count per bit, and it chooses calibration characters whose bit 0 is 1. Random bytes, random stop counts and a random switch of the outgoing polarity are mixed with directed glitches, a half-rate NULL break during an active transmission, and a recalibration at a different rate.

// File: rtl/abh_pkg.sv
package abh_pkg;

    localparam int DATA_BITS  = 8;
    localparam int FRAME_BITS = DATA_BITS + 2;

    typedef enum logic [2:0] {
        RX_CAL_IDLE,
        RX_CAL_WAIT,
        RX_CAL_MEAS,
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_st_e;

    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 vld;
    } rx_byte_s;

    // cycles to wait from an edge to the middle of a bit, minus the load cycle
    function automatic int unsigned mid_wait(input int unsigned period);
        return (period >> 1) - 1;
    endfunction

endpackage

// File: rtl/abh_sync.sv
module abh_sync #(
    parameter int   STAGES   = 2,
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{IDLE_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/abh_rx.sv
module abh_rx
    import abh_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int MIN_BIT = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_i,
    output logic [CNT_W-1:0] period_o,
    output logic             cal_done_o,
    output rx_byte_s         rx_o,
    output logic             brk_o
);
    localparam int IDX_W = $clog2(DATA_BITS);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] MIN_V   = CNT_W'(MIN_BIT);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
    localparam logic [IDX_W-1:0] LAST    = IDX_W'(DATA_BITS - 1);

    rx_st_e               st;
    logic [CNT_W-1:0]     cnt;
    logic [CNT_W-1:0]     period;
    logic [IDX_W-1:0]     idx;
    logic [DATA_BITS-1:0] sh;
    logic                 discard;
    logic                 cal_done;
    logic                 tick;
    logic                 clr;

    assign tick  = (cnt == '0);
    assign brk_o = (st == RX_STOP) && tick && !line_i;
    assign clr   = rst | brk_o;

    always_ff @(posedge clk) begin
        if (clr) begin
            st       <= RX_CAL_IDLE;
            cnt      <= '0;
            period   <= '0;
            idx      <= '0;
            sh       <= '0;
            discard  <= 1'b0;
            cal_done <= 1'b0;
            rx_o     <= '0;
        end else begin
            rx_o.vld <= 1'b0;
            case (st)
                RX_CAL_IDLE: if (line_i) st <= RX_CAL_WAIT;
                RX_CAL_WAIT: if (!line_i) begin
                    st  <= RX_CAL_MEAS;
                    cnt <= ONE;
                end
                RX_CAL_MEAS: begin
                    if (!line_i) begin
                        if (cnt != CNT_MAX) cnt <= cnt + ONE;
                    end else if (cnt >= MIN_V) begin
                        period  <= cnt;
                        cnt     <= CNT_W'(mid_wait(int'(cnt)));
                        idx     <= '0;
                        discard <= 1'b1;
                        st      <= RX_DATA;
                    end else begin
                        st <= RX_CAL_WAIT;
                    end
                end
                RX_IDLE: if (!line_i) begin
                    st  <= RX_START;
                    cnt <= CNT_W'(mid_wait(int'(period)));
                end
                RX_START: begin
                    if (!tick) cnt <= cnt - ONE;
                    else if (!line_i) begin
                        st      <= RX_DATA;
                        cnt     <= period - ONE;
                        idx     <= '0;
                        discard <= 1'b0;
                    end else st <= RX_IDLE;
                end
                RX_DATA: begin
                    if (!tick) cnt <= cnt - ONE;
                    else begin
                        sh  <= {line_i, sh[DATA_BITS-1:1]};
                        cnt <= period - ONE;
                        if (idx == LAST) st <= RX_STOP;
                        else             idx <= idx + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (!tick) cnt <= cnt - ONE;
                    else begin
                        st <= RX_IDLE;
                        if (discard) cal_done <= 1'b1;
                        else begin
                            rx_o.data <= sh;
                            rx_o.vld  <= 1'b1;
                        end
                    end
                end
                default: st <= RX_CAL_IDLE;
            endcase
        end
    end

    assign period_o   = period;
    assign cal_done_o = cal_done;

    AST_PERIOD_MIN: assert property (@(posedge clk) disable iff (rst)
        cal_done |-> (period >= MIN_V)); // R6
    AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (rst)
        (cal_done && !brk_o) |=> $stable(period)); // R5
    AST_NO_BYTE_UNCAL: assert property (@(posedge clk) disable iff (rst)
        rx_o.vld |-> cal_done); // R11
    AST_BRK_RECAL: assert property (@(posedge clk) disable iff (rst)
        brk_o |=> (!cal_done && !rx_o.vld)); // R8
    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
        rx_o.vld |=> !rx_o.vld); // R1
endmodule

// File: rtl/abh_tx.sv
module abh_tx
    import abh_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 clr,
    input  logic                 en,
    input  logic [CNT_W-1:0]     period_i,
    input  logic [DATA_BITS-1:0] data_i,
    input  logic                 vld_i,
    output logic                 ready_o,
    output logic                 line_o
);
    localparam int NB_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic                  busy;
    logic [FRAME_BITS-1:0] sh;
    logic [CNT_W-1:0]      cnt;
    logic [NB_W-1:0]       nb;

    assign ready_o = en && !busy;
    assign line_o  = busy ? sh[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (clr) begin
            busy <= 1'b0;
            sh   <= '1;
            cnt  <= '0;
            nb   <= '0;
        end else if (!busy) begin
            if (vld_i && ready_o) begin
                busy <= 1'b1;
                sh   <= {1'b1, data_i, 1'b0};
                cnt  <= period_i - ONE;
                nb   <= NB_W'(FRAME_BITS - 1);
            end
        end else if (cnt == '0) begin
            if (nb == '0) busy <= 1'b0;
            else begin
                sh  <= {1'b1, sh[FRAME_BITS-1:1]};
                nb  <= nb - 1'b1;
                cnt <= period_i - ONE;
            end
        end else begin
            cnt <= cnt - ONE;
        end
    end

    AST_TX_ACCEPT: assert property (@(posedge clk) disable iff (clr)
        (vld_i && ready_o) |=> !ready_o); // R3
    AST_TX_ONE_STOP: assert property (@(posedge clk) disable iff (clr)
        (busy && nb == '0) |-> line_o); // R3
    AST_TX_START_LOW: assert property (@(posedge clk) disable iff (clr)
        $rose(busy) |-> !line_o); // R3
endmodule

// File: rtl/autobaud_host_if.sv
module autobaud_host_if
    import abh_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int MIN_BIT = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ser_in,
    output logic       ser_out,
    input  logic       cfg_inv,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    input  logic       go_data,
    input  logic       go_cmd,
    output logic       cmd_mode,
    output logic       mreset_pulse
);
    logic             line_s;
    logic [CNT_W-1:0] period;
    logic             cal_done;
    rx_byte_s         rx_res;
    logic             brk;
    logic             tx_line;
    logic             mclr;

    assign mclr = rst | brk;

    abh_sync #(.STAGES(2), .IDLE_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ser_in),
        .q   (line_s)
    );

    abh_rx #(.CNT_W(CNT_W), .MIN_BIT(MIN_BIT)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .line_i     (line_s),
        .period_o   (period),
        .cal_done_o (cal_done),
        .rx_o       (rx_res),
        .brk_o      (brk)
    );

    abh_tx #(.CNT_W(CNT_W)) u_tx (
        .clk      (clk),
        .clr      (mclr),
        .en       (cal_done),
        .period_i (period),
        .data_i   (tx_data),
        .vld_i    (tx_valid),
        .ready_o  (tx_ready),
        .line_o   (tx_line)
    );

    always_ff @(posedge clk) begin
        if (mclr)         cmd_mode <= 1'b1;
        else if (go_cmd)  cmd_mode <= 1'b1;
        else if (go_data) cmd_mode <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) mreset_pulse <= 1'b0;
        else     mreset_pulse <= brk;
    end

    assign ser_out  = tx_line ^ cfg_inv;
    assign rx_data  = rx_res.data;
    assign rx_valid = rx_res.vld;

    AST_MRST_STATE: assert property (@(posedge clk) disable iff (rst)
        mreset_pulse |-> (cmd_mode && !tx_ready && (ser_out == !cfg_inv))); // R8
    AST_MODE_DATA: assert property (@(posedge clk) disable iff (rst)
        (go_data && !go_cmd && !brk) |=> !cmd_mode); // R10
    AST_MODE_CMD: assert property (@(posedge clk) disable iff (rst)
        go_cmd |=> cmd_mode); // R10
    AST_NO_TX_UNCAL: assert property (@(posedge clk) disable iff (rst)
        mreset_pulse |-> !rx_valid); // R11
endmodule

// File: tb/autobaud_host_if_tb.sv
module autobaud_host_if_tb_top;
    localparam int BIT  = 40;
    localparam int BIT2 = 24;

    logic       clk = 1'b0;
    logic       rst;
    logic       ser_in;
    logic       ser_out;
    logic       cfg_inv;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready;
    logic       go_data;
    logic       go_cmd;
    logic       cmd_mode;
    logic       mreset_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    int n_mrst  = 0;
    logic [7:0] rxq[$];

    always #2.5 clk = ~clk;

    autobaud_host_if #(.CNT_W(16), .MIN_BIT(8)) dut_i (
        .clk(clk), .rst(rst), .ser_in(ser_in), .ser_out(ser_out),
        .cfg_inv(cfg_inv), .rx_data(rx_data), .rx_valid(rx_valid),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .go_data(go_data), .go_cmd(go_cmd), .cmd_mode(cmd_mode),
        .mreset_pulse(mreset_pulse)
    );

    always @(negedge clk) begin
        if (rx_valid) rxq.push_back(rx_data);
        if (mreset_pulse) n_mrst++;
    end

    // expected line level at frame position pos (0 start, 1..8 data, 9 stop)
    function automatic logic frame_level(input logic [7:0] b, input int pos, input logic inv);
        logic v;
        if (pos == 0)      v = 1'b0;
        else if (pos == 9) v = 1'b1;
        else               v = b[pos-1];
        return v ^ inv;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input int bl, input int nstop);
        ser_in = 1'b0;
        tick(bl);
        for (int i = 0; i < 8; i++) begin
            ser_in = b[i];
            tick(bl);
        end
        ser_in = 1'b1;
        tick(bl * nstop);
    endtask

    task automatic expect_rx(input logic [7:0] b, input string req);
        if (rxq.size() != 1) chk(1'b0, req, rxq.size(), 1);
        else chk(rxq[0] == b, req, rxq[0], b);
        rxq.delete();
    endtask

    task automatic tx_and_decode(input logic [7:0] b, input int bl, input string req);
        logic [7:0] got;
        logic bad_frame;
        int guard;
        guard = 0;
        while (!tx_ready && guard < 2000) begin
            tick(1);
            guard++;
        end
        tx_data  = b;
        tx_valid = 1'b1;
        tick(1);
        tx_valid = 1'b0;
        bad_frame = 1'b0;
        got = '0;
        tick(bl / 2);
        if (ser_out != frame_level(b, 0, cfg_inv)) bad_frame = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(bl);
            got[i] = ser_out ^ cfg_inv;
        end
        tick(bl);
        if (ser_out != frame_level(b, 9, cfg_inv)) bad_frame = 1'b1;
        chk(!bad_frame && got == b, req, got, b);
        tick(bl / 2 - 1);
        chk(tx_ready == 1'b0, {req, " ready low through stop"}, tx_ready, 0);
        tick(1);
        chk(tx_ready == 1'b1, {req, " ready after 10 periods"}, tx_ready, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] b;
        int ns;
        bit seen;
        void'($urandom(32'h5eed));
        rst = 1'b1; ser_in = 1'b1; cfg_inv = 1'b0;
        tx_data = '0; tx_valid = 1'b0; go_data = 1'b0; go_cmd = 1'b0;
        tick(5);
        chk(cmd_mode == 1'b1, "R4 cmd_mode in reset", cmd_mode, 1);
        chk(tx_ready == 1'b0, "R4 tx_ready in reset", tx_ready, 0);
        chk(ser_out == 1'b1, "R4 line idle", ser_out, 1);
        rst = 1'b0;
        tick(10);
        chk(tx_ready == 1'b0, "R11 not ready before calibration", tx_ready, 0);

        // R6: short low glitch before the calibration character
        ser_in = 1'b0; tick(3); ser_in = 1'b1; tick(20);
        chk(tx_ready == 1'b0, "R6 glitch does not calibrate", tx_ready, 0);
        send_byte(8'hC1, BIT, 1);
        tick(5);
        chk(rxq.size() == 0, "R5 calibration char not forwarded", rxq.size(), 0);
        chk(tx_ready == 1'b1, "R5 ready after calibration", tx_ready, 1);

        // R7: short glitch after calibration
        ser_in = 1'b0; tick(5); ser_in = 1'b1; tick(BIT);
        chk(rxq.size() == 0, "R7 glitch rejected", rxq.size(), 0);
        send_byte(8'h5A, BIT, 1);
        expect_rx(8'h5A, "R1 byte after glitch");

        send_byte(8'h00, BIT, 1);
        expect_rx(8'h00, "R1 all zeros");
        send_byte(8'hFF, BIT, 1);
        expect_rx(8'hFF, "R1 all ones");
        for (int k = 0; k < 10; k++) begin
            b  = 8'($urandom);
            ns = 1 + int'($urandom % 2);
            send_byte(b, BIT, ns);
            expect_rx(b, ns == 2 ? "R2 two stop bits" : "R1 random byte");
        end

        // R3 transmit, then R9 inverted line
        for (int k = 0; k < 4; k++) tx_and_decode(8'($urandom), BIT, "R3 tx frame");
        cfg_inv = 1'b1;
        tick(2);
        chk(ser_out == 1'b0, "R9 inverted idle", ser_out, 0);
        for (int k = 0; k < 2; k++) tx_and_decode(8'($urandom), BIT, "R9 inverted tx frame");
        cfg_inv = 1'b0;

        // R10 mode flag
        go_data = 1'b1; tick(1); go_data = 1'b0;
        chk(cmd_mode == 1'b0, "R10 go_data", cmd_mode, 0);
        go_cmd = 1'b1; go_data = 1'b1; tick(1); go_cmd = 1'b0; go_data = 1'b0;
        chk(cmd_mode == 1'b1, "R10 go_cmd priority", cmd_mode, 1);
        go_data = 1'b1; tick(1); go_data = 1'b0;
        chk(cmd_mode == 1'b0, "R10 back to data", cmd_mode, 0);

        // R8: half-rate NULL during a transmission
        tx_data = 8'h96; tx_valid = 1'b1; tick(1); tx_valid = 1'b0;
        seen = 1'b0;
        fork
            send_byte(8'h00, 2 * BIT, 1);
            begin
                for (int i = 0; i < 2000; i++) begin
                    @(negedge clk);
                    if (mreset_pulse) begin
                        seen = 1'b1;
                        break;
                    end
                end
                chk(seen, "R8 mreset_pulse", seen, 1);
                chk(cmd_mode == 1'b1, "R8 command mode", cmd_mode, 1);
                chk(tx_ready == 1'b0, "R8 tx_ready low", tx_ready, 0);
                chk(ser_out == 1'b1, "R8 tx aborted, line idle", ser_out, 1);
                tick(1);
                chk(mreset_pulse == 1'b0, "R8 one-cycle pulse", mreset_pulse, 0);
            end
        join
        chk(rxq.size() == 0, "R8 broken frame not delivered", rxq.size(), 0);
        chk(n_mrst == 1, "R8 single master reset", n_mrst, 1);
        rxq.delete();

        // R5: recalibration at a different rate
        send_byte(8'h33, BIT2, 1);
        tick(3);
        chk(rxq.size() == 0, "R5 recalibration char absorbed", rxq.size(), 0);
        chk(tx_ready == 1'b1, "R5 ready after recalibration", tx_ready, 1);
        send_byte(8'hA7, BIT2, 1);
        expect_rx(8'hA7, "R5 byte at new rate");
        tx_and_decode(8'h3C, BIT2, "R5 tx at new rate");

        tick(10);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule